// File: doc/BRIEF.md
# Standby Clock Gating Controller

This block decides which internal clocks of a small processor system may run while the system enters, sits in and leaves its two low-power states. The first is a light wait state that only halts instruction execution. The second is a deep stop state that also halts the oscillator. The controller runs on an always-on reference clock. It takes single-cycle entry requests and an accepted-interrupt indication. From these it drives five enables: oscillator, base clock, divided peripheral clocks, CPU clock and bus-interface clock. The gate cells that the enables steer are outside this block. A divided clock that is gated off parks high. The base, CPU and bus clocks park low when gated off.

In the light state a configuration bit picks between two variants. One stops only the CPU and bus clocks. The other also stops the base and divided clocks, so the peripherals and the watchdog halt as well. The bit is sampled when the request is accepted.

Entering the deep state asks the watchdog to preload its counter and to switch to its stabilisation clock. On an interrupt exit, a select bit picks how the CPU and bus clocks come back. With the bit at 0 they wait until the watchdog MSB reads 0. With the bit at 1 they wait for the first falling edge of the divide-by-16 peripheral clock. Reset always returns straight to normal running.

Top module: `stby_clk_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, all five enables are 1 after that edge, and wdt_preload and wdt_src_force are 0.
- R2: A wait_req accepted in run with pstop_cfg = 0 leaves osc_en, base_clk_en and pclk_en at 1 and sets cpu_clk_en and bus_clk_en to 0 from the next cycle on.
- R3: A wait_req accepted in run with pstop_cfg = 1 keeps osc_en at 1 and sets the other four enables to 0.
- R4: A stop_req accepted in run sets all five enables to 0. It raises wdt_preload for exactly the first cycle of the stop state, and it sets wdt_src_force.
- R5: An irq_ack sampled in either wait variant sets all five enables to 1 from the next cycle.
- R6: wait_req and stop_req sampled outside the run state have no effect on any enable.
- R7: An irq_ack sampled in stop with stp_ret_sel = 0 sets osc_en, base_clk_en and pclk_en to 1 at once. cpu_clk_en and bus_clk_en stay 0 until wdt_msb is sampled at 0, and they become 1 in the following cycle.
- R8: An irq_ack sampled in stop with stp_ret_sel = 1 restores osc_en, base_clk_en and pclk_en at once. cpu_clk_en and bus_clk_en become 1 in the cycle after pf16_lvl is sampled at 0 when it was 1 at the previous edge. A further irq_ack during this wait has no effect.
- R9: Reset in any low-power state, including stop and both return waits, restores all enables in the next cycle without any watchdog wait.
- R10: When wait_req and stop_req are both sampled at 1 in run, the stop state is entered.
- R11: wdt_src_force stays 1 after a stop entry until wdt_msb is sampled at 0 outside the stop state, and it falls in the following cycle.
- R12: irq_ack sampled in the run state has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_req | input | 1 | Request to enter the wait state |
| stop_req | input | 1 | Request to enter the stop state |
| irq_ack | input | 1 | Interrupt accepted; exit condition |
| pstop_cfg | input | 1 | 1: wait state also halts base and divided clocks |
| stp_ret_sel | input | 1 | Stop return mode: 0 watchdog MSB, 1 divide-by-16 falling edge |
| wdt_msb | input | 1 | Most significant bit of the watchdog counter |
| pf16_lvl | input | 1 | Level of the divide-by-16 peripheral clock |
| osc_en | output | 1 | Oscillator enable |
| base_clk_en | output | 1 | Base clock enable (parks low) |
| pclk_en | output | 1 | Divided peripheral and watchdog clock enable (parks high) |
| cpu_clk_en | output | 1 | CPU clock enable (parks low) |
| bus_clk_en | output | 1 | Bus-interface clock enable (parks low) |
| wdt_preload | output | 1 | One-cycle request to preload the watchdog to all ones |
| wdt_src_force | output | 1 | Watchdog held on its stabilisation clock source |

## Verification
The assertions assume that every input is synchronous to clk. They also assume that pf16_lvl comes from a running divider, so a falling edge eventually arrives after a stop exit, and that wdt_msb is driven every cycle. The stimulus respects both assumptions by driving all inputs just after the falling edge of clk. It also toggles pf16_lvl and wdt_msb freely and lets nothing depend on a clock that the block itself has gated. Requests, interrupts and the rare reset pulse are drawn at random densities. This sends the random runs through every state, including entries attempted from each low-power state.

// File: rtl/stby_pkg.sv
// Shared types for the standby clock controller.
// Assumes: one state encoding shared by the sequencer and the enable decoder.
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_WAIT_P = 3'd1,   // wait, peripherals running
        ST_WAIT_A = 3'd2,   // wait, peripherals halted
        ST_STOP   = 3'd3,
        ST_STAB_W = 3'd4,   // stop return, waiting on watchdog MSB
        ST_STAB_E = 3'd5    // stop return, waiting on divider falling edge
    } stby_st_e;

    typedef struct packed {
        logic osc;
        logic base;
        logic pclk;
        logic cpu;
        logic bus;
    } clk_en_t;

    localparam int EN_W = $bits(clk_en_t);

endpackage

// File: rtl/stby_fall_det.sv
// Falling-edge detector for a slow divided clock level.
// Assumes: lvl is synchronous to clk; IDLE_LVL is the parked level after reset.
module stby_fall_det #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= lvl;
    end

    // High at the last edge, low now.
    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/stby_seq.sv
// Standby sequencer: tracks run, wait, stop and the two stop-return waits,
// and raises the watchdog preload and source-force requests.
// Assumes: inputs synchronous to clk; wait variant chosen when the request is accepted.
module stby_seq
    import stby_pkg::*;
#(
    parameter bit STOP_FIRST = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wait_req,
    input  logic     stop_req,
    input  logic     irq_ack,
    input  logic     pstop_cfg,
    input  logic     stp_ret_sel,
    input  logic     wdt_msb,
    input  logic     pf16_fall,
    output stby_st_e state,
    output logic     preload,
    output logic     force_src
);
    stby_st_e state_q, state_d;
    logic     go_wait, go_stop;
    logic     preload_q, force_q;

    // Pick request priority when both arrive together.
    generate
        if (STOP_FIRST) begin : g_stop_first
            assign go_stop = stop_req;
            assign go_wait = wait_req & ~stop_req;
        end else begin : g_wait_first
            assign go_wait = wait_req;
            assign go_stop = stop_req & ~wait_req;
        end
    endgenerate

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (go_stop)      state_d = ST_STOP;
                else if (go_wait) state_d = pstop_cfg ? ST_WAIT_A : ST_WAIT_P;
            end
            ST_WAIT_P, ST_WAIT_A: begin
                if (irq_ack) state_d = ST_RUN;
            end
            ST_STOP: begin
                if (irq_ack) state_d = stp_ret_sel ? ST_STAB_E : ST_STAB_W;
            end
            ST_STAB_W: begin
                if (!wdt_msb) state_d = ST_RUN;
            end
            ST_STAB_E: begin
                if (pf16_fall) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Watchdog preload pulse and clock-source force flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= 1'b0;
            force_q   <= 1'b0;
        end else begin
            preload_q <= (state_q == ST_RUN) && go_stop;
            if ((state_q == ST_RUN) && go_stop)
                force_q <= 1'b1;
            else if (!wdt_msb && (state_q != ST_STOP))
                force_q <= 1'b0;
        end
    end

    assign state     = state_q;
    assign preload   = preload_q;
    assign force_src = force_q;

    p_wait_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_P || state_q == ST_WAIT_A) && irq_ack) |=> (state_q == ST_RUN));

    p_wait_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_P) && !irq_ack) |=> (state_q == ST_WAIT_P));

    p_preload_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        preload_q |=> !preload_q);

    p_stab_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STAB_W) && wdt_msb) |=> (state_q == ST_STAB_W));

    p_edge_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STAB_E) && !pf16_fall) |=> (state_q == ST_STAB_E));

    p_both_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && wait_req && stop_req && STOP_FIRST) |=> (state_q == ST_STOP));

endmodule

// File: rtl/stby_en_map.sv
// Enable decoder: turns the sequencer state into the five clock enables.
// Assumes: a cleared enable makes the downstream gate park at its own idle level.
module stby_en_map
    import stby_pkg::*;
(
    input  stby_st_e state,
    output clk_en_t  en
);
    // Per-state enable pattern.
    always_comb begin
        unique case (state)
            ST_RUN:               en = '{osc: 1'b1, base: 1'b1, pclk: 1'b1, cpu: 1'b1, bus: 1'b1};
            ST_WAIT_P:            en = '{osc: 1'b1, base: 1'b1, pclk: 1'b1, cpu: 1'b0, bus: 1'b0};
            ST_WAIT_A:            en = '{osc: 1'b1, base: 1'b0, pclk: 1'b0, cpu: 1'b0, bus: 1'b0};
            ST_STOP:              en = '{osc: 1'b0, base: 1'b0, pclk: 1'b0, cpu: 1'b0, bus: 1'b0};
            ST_STAB_W, ST_STAB_E: en = '{osc: 1'b1, base: 1'b1, pclk: 1'b1, cpu: 1'b0, bus: 1'b0};
            default:              en = '{osc: 1'b1, base: 1'b1, pclk: 1'b1, cpu: 1'b1, bus: 1'b1};
        endcase
    end

endmodule

// File: rtl/stby_clk_ctrl.sv
// Standby clock gating controller top: sequencer, divider edge detector, enable decoder.
// Assumes: clk is always on; rst_n synchronous active-low; all inputs synchronous to clk.
module stby_clk_ctrl
    import stby_pkg::*;
#(
    parameter bit   STOP_FIRST = 1'b1,
    parameter logic PF_IDLE    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_req,
    input  logic stop_req,
    input  logic irq_ack,
    input  logic pstop_cfg,
    input  logic stp_ret_sel,
    input  logic wdt_msb,
    input  logic pf16_lvl,
    output logic osc_en,
    output logic base_clk_en,
    output logic pclk_en,
    output logic cpu_clk_en,
    output logic bus_clk_en,
    output logic wdt_preload,
    output logic wdt_src_force
);
    stby_st_e st;
    clk_en_t  en;
    logic     pf16_fall;

    stby_fall_det #(.IDLE_LVL(PF_IDLE)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pf16_lvl),
        .fall  (pf16_fall)
    );

    stby_seq #(.STOP_FIRST(STOP_FIRST)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_req    (wait_req),
        .stop_req    (stop_req),
        .irq_ack     (irq_ack),
        .pstop_cfg   (pstop_cfg),
        .stp_ret_sel (stp_ret_sel),
        .wdt_msb     (wdt_msb),
        .pf16_fall   (pf16_fall),
        .state       (st),
        .preload     (wdt_preload),
        .force_src   (wdt_src_force)
    );

    stby_en_map u_map (
        .state (st),
        .en    (en)
    );

    assign osc_en      = en.osc;
    assign base_clk_en = en.base;
    assign pclk_en     = en.pclk;
    assign cpu_clk_en  = en.cpu;
    assign bus_clk_en  = en.bus;

    p_reset_run_r1: assert property (@(posedge clk)
        !rst_n |=> (osc_en && base_clk_en && pclk_en && cpu_clk_en && bus_clk_en && !wdt_preload));

    p_stop_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && stop_req) |=> (!osc_en && wdt_preload && wdt_src_force));

    p_run_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && irq_ack && !wait_req && !stop_req) |=> cpu_clk_en);

endmodule

// File: tb/stby_clk_ctrl_tb.sv
`timescale 1ns/1ps
module stby_clk_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_req = 1'b0, stop_req = 1'b0, irq_ack = 1'b0;
    logic pstop_cfg = 1'b0, stp_ret_sel = 1'b0, wdt_msb = 1'b1, pf16_lvl = 1'b1;
    logic osc_en, base_clk_en, pclk_en, cpu_clk_en, bus_clk_en, wdt_preload, wdt_src_force;

    int n_cmp = 0;
    int n_bad = 0;
    int m_st = 0;          // 0 run,1 wait_p,2 wait_a,3 stop,4 stab_w,5 stab_e
    logic m_prev = 1'b1;
    logic m_pre = 1'b0;
    logic m_force = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stby_clk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .irq_ack(irq_ack), .pstop_cfg(pstop_cfg), .stp_ret_sel(stp_ret_sel),
        .wdt_msb(wdt_msb), .pf16_lvl(pf16_lvl), .osc_en(osc_en),
        .base_clk_en(base_clk_en), .pclk_en(pclk_en), .cpu_clk_en(cpu_clk_en),
        .bus_clk_en(bus_clk_en), .wdt_preload(wdt_preload), .wdt_src_force(wdt_src_force)
    );

    // Expected enables {osc, base, pclk, cpu, bus} per the requirements.
    function automatic logic [4:0] exp_en(int st);
        case (st)
            1:       return 5'b11100;
            2:       return 5'b10000;
            3:       return 5'b00000;
            4, 5:    return 5'b11100;
            default: return 5'b11111;
        endcase
    endfunction

    function automatic string req_of(int st);
        case (st)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R7";
            5: return "R8";
            default: return "R5";
        endcase
    endfunction

    // Advance the bench model by one clock edge using the driven inputs.
    task automatic model_edge();
        logic fall;
        int   nx;
        logic pre_n, frc_n;
        if (!rst_n) begin
            m_st = 0; m_prev = 1'b1; m_pre = 1'b0; m_force = 1'b0;
            return;
        end
        fall  = m_prev && !pf16_lvl;
        nx    = m_st;
        pre_n = 1'b0;
        frc_n = m_force;
        case (m_st)
            0: if (stop_req) nx = 3; else if (wait_req) nx = pstop_cfg ? 2 : 1;
            1, 2: if (irq_ack) nx = 0;
            3: if (irq_ack) nx = stp_ret_sel ? 5 : 4;
            4: if (!wdt_msb) nx = 0;
            5: if (fall) nx = 0;
            default: nx = 0;
        endcase
        if (m_st == 0 && stop_req) begin pre_n = 1'b1; frc_n = 1'b1; end
        else if (!wdt_msb && m_st != 3) frc_n = 1'b0;
        m_st = nx; m_pre = pre_n; m_force = frc_n; m_prev = pf16_lvl;
    endtask

    task automatic cmp(string tag, logic [6:0] act, logic [6:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b (osc,base,pclk,cpu,bus,pre,force)", tag, act, expv);
        end
    endtask

    // One clock: model at the rising edge, compare just after the falling edge.
    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp(tag, {osc_en, base_clk_en, pclk_en, cpu_clk_en, bus_clk_en, wdt_preload, wdt_src_force},
            {exp_en(m_st), m_pre, m_force});
    endtask

    task automatic idle_in();
        wait_req = 0; stop_req = 0; irq_ack = 0; rst_n = 1;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        rst_n = 0;                         cyc("R1 reset");
        rst_n = 1;                         cyc("R1 after reset");
        irq_ack = 1;                       cyc("R12 irq in run");
        idle_in(); pstop_cfg = 0; wait_req = 1; cyc("R2 wait pclk on");
        idle_in(); stop_req = 1;           cyc("R6 stop ignored in wait");
        idle_in(); wait_req = 1;           cyc("R6 wait ignored in wait");
        idle_in(); irq_ack = 1;            cyc("R5 wait exit");
        idle_in(); pstop_cfg = 1; wait_req = 1; cyc("R3 wait all off");
        idle_in(); pstop_cfg = 0;          cyc("R3 hold after cfg change");
        irq_ack = 1;                       cyc("R5 wait_all exit");
        idle_in(); wait_req = 1; stop_req = 1; wdt_msb = 1; cyc("R10 both req stop wins");
        idle_in();                         cyc("R4 preload falls");
        wait_req = 1;                      cyc("R6 wait ignored in stop");
        idle_in(); stp_ret_sel = 0; irq_ack = 1; cyc("R7 stop exit osc on");
        idle_in();                         cyc("R7 hold msb high");
        irq_ack = 1;                       cyc("R7 irq ignored while stabilising");
        idle_in(); wdt_msb = 0;            cyc("R7 msb low cpu on");
        wdt_msb = 1;                       cyc("R11 force cleared");
        stop_req = 1;                      cyc("R4 stop again");
        idle_in(); stp_ret_sel = 1; pf16_lvl = 1; irq_ack = 1; cyc("R8 stop exit edge mode");
        idle_in(); wdt_msb = 0;            cyc("R8 msb ignored in edge mode");
        wdt_msb = 1; irq_ack = 1;          cyc("R8 irq ignored");
        idle_in(); pf16_lvl = 0;           cyc("R8 falling edge");
        pf16_lvl = 1;                      cyc("R8 running");
        stop_req = 1;                      cyc("R4 stop third");
        idle_in(); rst_n = 0;              cyc("R9 reset in stop");
        rst_n = 1; stop_req = 1;           cyc("R4 stop fourth");
        idle_in(); stp_ret_sel = 0; irq_ack = 1; cyc("R7 to stab");
        idle_in(); rst_n = 0;              cyc("R9 reset in stab");
        idle_in();                         cyc("R1 run after reset");

        for (int i = 0; i < 4000; i++) begin
            rst_n       = ($urandom % 100) != 0;
            wait_req    = ($urandom % 6) == 0;
            stop_req    = ($urandom % 9) == 0;
            irq_ack     = ($urandom % 5) == 0;
            pstop_cfg   = $urandom % 2;
            stp_ret_sel = $urandom % 2;
            wdt_msb     = ($urandom % 4) != 0;
            pf16_lvl    = $urandom % 2;
            cyc(req_of(m_st));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule